// File: doc/BRIEF.md
# FIFO Flag Offset Register Unit

This unit keeps the two thresholds that a FIFO uses for its almost-empty and almost-full flags: an empty-side offset and a full-side offset. Both take a preset value at reset that depends on the FIFO depth. Software or a host changes them through the FIFO's own write port: while the active-low program strobe is held, each write-clock edge with the write enable active stores the low bits of the input word into one offset, first the empty-side offset and then the full-side one. A two-entry pointer selects the target and wraps back after the full-side offset.

The offsets can also be read back over the FIFO's output bus. With the program strobe and the read enable both active, each read-clock edge places one offset on the low bits of the output word: the empty-side offset first, then the full-side offset, then the empty-side offset again. This path is only open in standard mode. When first-word-fall-through mode is selected, the output bus is left as it is. While the offsets are being read back, the unit tells the FIFO not to advance its read pointer. The held offsets are also driven out to the flag comparators.

Top module: `fifo_ofs_unit`

## Requirements
- R1: After reset both offsets equal the preset for the depth (31 for a depth of 256, 63 for 512, 127 for any deeper FIFO), and the output bus is all zero.
- R2: A write-clock edge with `load_n`=0 and `wr_en_n`=0 stores `wdata[11:0]` into the empty-side offset if the write pointer is at the empty slot, and into the full-side offset on the next such edge. The other offset is left unchanged.
- R3: After the full-side offset is written, the write pointer wraps, and the next programming write goes to the empty-side offset.
- R4: A write-clock edge with `load_n`=1 or `wr_en_n`=1 changes neither offset and does not move the write pointer.
- R5: In standard mode (`fwft_mode`=0), a read-clock edge with `load_n`=0 and `rd_en_n`=0 drives the offset at the read pointer onto `rdata[11:0]`. The sequence is empty-side, then full-side, and then it wraps.
- R6: With `fwft_mode`=1, readback is blocked. `rdata` keeps its value and the read pointer does not move.
- R7: `rdata` keeps its value on any read-clock edge that is not a readback edge.
- R8: `fifo_rd_ok` is 1 exactly when `rd_en_n`=0 and `load_n`=1. It is 0 during readback.
- R9: Reset returns both the write pointer and the read pointer to the empty slot.
- R10: Bits of `wdata` above bit 11 are not stored, and bits of `rdata` above bit 11 are 0 after a readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Program strobe for the offsets, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| fwft_mode | input | 1 | 1 selects first-word-fall-through mode |
| wdata | input | 18 | Input data word |
| rdata | output | 18 | Output data word carrying the read-back offsets |
| ae_offset | output | 12 | Empty-side offset, sent to the flag logic |
| af_offset | output | 12 | Full-side offset, sent to the flag logic |
| fifo_rd_ok | output | 1 | Allows the FIFO read pointer to advance |

## Verification
The bench programs past the wrap point and interleaves writes that are ignored, to confirm the pointer neither skips nor stalls. A design that advanced the pointer on a blocked write would put the next value into the wrong offset. Readback is taken through a full wrap and then tried in first-word-fall-through mode. A design that leaked the offsets or moved the read pointer there would show a changed bus, or the wrong offset on the next standard read. Finally, both pointers are left part-way through their sequence and a reset is applied. Pointers that survive reset would make the first write or the first readback land on the full-side offset.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

   typedef enum logic {
      SLOT_AE = 1'b0,
      SLOT_AF = 1'b1
   } ofs_slot_e;

   // Preset threshold chosen from the FIFO depth
   function automatic int unsigned preset_offset(input int unsigned depth);
      if (depth <= 256)
         return 31;
      else if (depth <= 512)
         return 63;
      else
         return 127;
   endfunction

   function automatic ofs_slot_e next_slot(input ofs_slot_e s);
      return (s == SLOT_AE) ? SLOT_AF : SLOT_AE;
   endfunction

endpackage

// File: rtl/fifo_ofs_wbank.sv
module fifo_ofs_wbank
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned OFS_W  = 12,
   parameter int unsigned DEPTH  = 1024
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [OFS_W-1:0]  ae_ofs,
   output logic [OFS_W-1:0]  af_ofs
);

   localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(preset_offset(DEPTH));
   localparam int unsigned      N_SLOT  = 2;

   logic                wr_fire;
   ofs_slot_e           slot_q;
   logic [OFS_W-1:0]    ofs_q [N_SLOT];

   assign wr_fire = !load_n && !wr_en_n;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= SLOT_AE;
      else if (wr_fire)
         slot_q <= next_slot(slot_q);
   end

   for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      always_ff @(posedge wclk or negedge rst_n) begin
         if (!rst_n)
            ofs_q[g] <= RST_VAL;
         else if (wr_fire && (int'(slot_q) == g))
            ofs_q[g] <= wdata[OFS_W-1:0];
      end
   end

   if (DATA_W > OFS_W) begin : g_hi
      logic wdata_hi_unused;
      assign wdata_hi_unused = ^wdata[DATA_W-1:OFS_W];
   end

   assign ae_ofs = ofs_q[0];
   assign af_ofs = ofs_q[1];

   // R2: a programming write at the empty slot lands in the empty-side offset
   p_ae_load_r2: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_fire && slot_q == SLOT_AE) |=> (ae_ofs == $past(wdata[OFS_W-1:0])) && $stable(af_ofs));

   // R3: the next write lands in the full-side offset
   p_af_load_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_fire && slot_q == SLOT_AF) |=> (af_ofs == $past(wdata[OFS_W-1:0])) && $stable(ae_ofs));

   // R4: no change without strobe and enable
   p_idle_hold_r4: assert property (@(posedge wclk) disable iff (!rst_n)
      !wr_fire |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(slot_q));

endmodule

// File: rtl/fifo_ofs_rdseq.sv
module fifo_ofs_rdseq
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned OFS_W  = 12
) (
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              rd_en_n,
   input  logic              fwft_mode,
   input  logic [OFS_W-1:0]  ae_ofs,
   input  logic [OFS_W-1:0]  af_ofs,
   output logic [DATA_W-1:0] rdata
);

   logic              rb_fire;
   ofs_slot_e         slot_q;
   logic [OFS_W-1:0]  sel_ofs;
   logic [DATA_W-1:0] rb_word;
   logic [DATA_W-1:0] rdata_q;

   assign rb_fire = !load_n && !rd_en_n && !fwft_mode;
   assign sel_ofs = (slot_q == SLOT_AE) ? ae_ofs : af_ofs;

   if (DATA_W > OFS_W) begin : g_pad
      assign rb_word = {{(DATA_W-OFS_W){1'b0}}, sel_ofs};
   end else begin : g_flat
      assign rb_word = sel_ofs;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= SLOT_AE;
         rdata_q <= '0;
      end else if (rb_fire) begin
         slot_q  <= next_slot(slot_q);
         rdata_q <= rb_word;
      end
   end

   assign rdata = rdata_q;

   // R5: a readback edge at the empty slot shows the empty-side offset
   p_first_ae_r5: assert property (@(posedge rclk) disable iff (!rst_n)
      (rb_fire && slot_q == SLOT_AE) |=> (rdata[OFS_W-1:0] == $past(ae_ofs)));

   // R6: first-word-fall-through mode leaves the bus alone
   p_fwft_block_r6: assert property (@(posedge rclk) disable iff (!rst_n)
      fwft_mode |=> $stable(rdata) && $stable(slot_q));

   // R7: no readback, no change
   p_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
      !rb_fire |=> $stable(rdata));

endmodule

// File: rtl/fifo_ofs_unit.sv
module fifo_ofs_unit
   import fifo_ofs_pkg::*;
#(
   parameter int unsigned DATA_W = 18,
   parameter int unsigned OFS_W  = 12,
   parameter int unsigned DEPTH  = 1024
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              load_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              fwft_mode,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [OFS_W-1:0]  ae_offset,
   output logic [OFS_W-1:0]  af_offset,
   output logic              fifo_rd_ok
);

   localparam int unsigned PRESET = preset_offset(DEPTH);

   if (OFS_W > DATA_W) begin : g_chk_w
      $error("offset width exceeds data width");
   end
   if (DEPTH < 256) begin : g_chk_d
      $error("depth below 256 words");
   end
   if ((64'd1 << OFS_W) <= 64'(PRESET)) begin : g_chk_p
      $error("offset width cannot hold the preset");
   end

   logic [OFS_W-1:0] ae_w;
   logic [OFS_W-1:0] af_w;

   fifo_ofs_wbank #(
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W),
      .DEPTH  (DEPTH)
   ) i_wbank (
      .wclk    (wclk),
      .rst_n   (rst_n),
      .load_n  (load_n),
      .wr_en_n (wr_en_n),
      .wdata   (wdata),
      .ae_ofs  (ae_w),
      .af_ofs  (af_w)
   );

   fifo_ofs_rdseq #(
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W)
   ) i_rdseq (
      .rclk      (rclk),
      .rst_n     (rst_n),
      .load_n    (load_n),
      .rd_en_n   (rd_en_n),
      .fwft_mode (fwft_mode),
      .ae_ofs    (ae_w),
      .af_ofs    (af_w),
      .rdata     (rdata)
   );

   assign ae_offset  = ae_w;
   assign af_offset  = af_w;
   assign fifo_rd_ok = !rd_en_n && load_n;

   // R8: the FIFO is never told to advance while the offsets are being read
   p_no_fifo_read_r8: assert property (@(posedge rclk) disable iff (!rst_n)
      (!load_n && !rd_en_n) |-> !fifo_rd_ok);

endmodule

// File: tb/test_fifo_ofs_unit.sv
module test_fifo_ofs_unit;

   logic        wclk = 1'b0;
   logic        rclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_n = 1'b1;
   logic        wr_en_n = 1'b1;
   logic        rd_en_n = 1'b1;
   logic        fwft_mode = 1'b0;
   logic [17:0] wdata = '0;
   logic [17:0] rdata, rdata_s;
   logic [11:0] ae_offset, af_offset, ae_s, af_s;
   logic        fifo_rd_ok, fifo_rd_ok_s;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 wclk = ~wclk;
   initial begin
      #1;
      forever #2 rclk = ~rclk;
   end

   fifo_ofs_unit i_fifo_ofs_unit (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n),
      .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .fwft_mode(fwft_mode),
      .wdata(wdata), .rdata(rdata), .ae_offset(ae_offset),
      .af_offset(af_offset), .fifo_rd_ok(fifo_rd_ok)
   );

   fifo_ofs_unit #(.DEPTH(256)) i_fifo_ofs_unit_small (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n),
      .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .fwft_mode(fwft_mode),
      .wdata(wdata), .rdata(rdata_s), .ae_offset(ae_s),
      .af_offset(af_s), .fifo_rd_ok(fifo_rd_ok_s)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge wclk);
      rst_n = 1'b0;
      repeat (3) @(negedge wclk);
      rst_n = 1'b1;
      @(negedge wclk);
   endtask

   task automatic wr_cycle(input logic ld, input logic we, input logic [17:0] d);
      @(negedge wclk);
      load_n = ld; wr_en_n = we; wdata = d;
      @(negedge wclk);
      load_n = 1'b1; wr_en_n = 1'b1;
   endtask

   task automatic rd_cycle(input logic ld, input logic re, input logic fw);
      @(negedge rclk);
      load_n = ld; rd_en_n = re; fwft_mode = fw;
      #1;
      chk("R8 fifo_rd_ok", 32'(fifo_rd_ok), 32'(!re && ld));
      @(negedge rclk);
      load_n = 1'b1; rd_en_n = 1'b1; fwft_mode = 1'b0;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R1 ae preset deep", 32'(ae_offset), 32'd127);
      chk("R1 af preset deep", 32'(af_offset), 32'd127);
      chk("R1 rdata zero", 32'(rdata), 32'd0);
      chk("R1 ae preset 256", 32'(ae_s), 32'd31);
      chk("R1 af preset 256", 32'(af_s), 32'd31);
   endtask

   task automatic t_program();
      wr_cycle(1'b0, 1'b0, 18'h30ABC);
      chk("R2/R10 ae written low bits", 32'(ae_offset), 32'hABC);
      chk("R2 af untouched", 32'(af_offset), 32'd127);
      wr_cycle(1'b0, 1'b0, 18'h00155);
      chk("R2 af written", 32'(af_offset), 32'h155);
      chk("R2 ae kept", 32'(ae_offset), 32'hABC);
      wr_cycle(1'b0, 1'b0, 18'h00222);
      chk("R3 wrap to ae", 32'(ae_offset), 32'h222);
      chk("R3 af kept", 32'(af_offset), 32'h155);
   endtask

   task automatic t_ignored_writes();
      wr_cycle(1'b1, 1'b0, 18'h00FFF);
      chk("R4 no strobe ae", 32'(ae_offset), 32'h222);
      chk("R4 no strobe af", 32'(af_offset), 32'h155);
      wr_cycle(1'b0, 1'b1, 18'h00FFF);
      chk("R4 no enable ae", 32'(ae_offset), 32'h222);
      chk("R4 no enable af", 32'(af_offset), 32'h155);
      wr_cycle(1'b0, 1'b0, 18'h00333);
      chk("R4 pointer held af", 32'(af_offset), 32'h333);
      chk("R4 pointer held ae", 32'(ae_offset), 32'h222);
   endtask

   task automatic t_readback();
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R5 first is ae", 32'(rdata), 32'h222);
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R5 second is af", 32'(rdata), 32'h333);
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R5/R10 wrap to ae, high bits zero", 32'(rdata), 32'h222);
   endtask

   task automatic t_hold();
      rd_cycle(1'b1, 1'b0, 1'b0);
      chk("R7 plain read holds", 32'(rdata), 32'h222);
      rd_cycle(1'b0, 1'b1, 1'b0);
      chk("R7 no enable holds", 32'(rdata), 32'h222);
   endtask

   task automatic t_fwft();
      rd_cycle(1'b0, 1'b0, 1'b1);
      chk("R6 fwft bus unchanged", 32'(rdata), 32'h222);
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R6 pointer held, af next", 32'(rdata), 32'h333);
   endtask

   task automatic t_reset_pointers();
      wr_cycle(1'b0, 1'b0, 18'h00444);
      chk("R2 ae rewritten", 32'(ae_offset), 32'h444);
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R5 ae after rewrite", 32'(rdata), 32'h444);
      do_reset();
      wr_cycle(1'b0, 1'b0, 18'h00555);
      chk("R9 write pointer reset", 32'(ae_offset), 32'h555);
      chk("R9 af preset kept", 32'(af_offset), 32'd127);
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R9 read pointer reset", 32'(rdata), 32'h555);
   endtask

   initial begin
      t_reset_state();
      t_program();
      t_ignored_writes();
      t_readback();
      t_hold();
      t_fwft();
      t_reset_pointers();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule